// File: doc/BRIEF.md
# SDRAM refresh and self-refresh sequencer

This block paces periodic auto-refresh for an SDRAM controller that drives two memory blocks at once. It also controls their low-power self-refresh state. A free-running interval timer counts out a programmable period in steps of 16 clocks. When the timer runs out, the block raises a refresh request and holds it until the access arbiter grants the command slot. It then issues one REF command to both blocks and holds a busy line high for a recovery window of 3, 6 or 9 clocks. While busy is high, the arbiter must not open a row.

A software-controlled request bit puts both SDRAMs into self-refresh. The SELF command is sent when the arbiter reports idle and no refresh recovery is running. SCKE is then held low and the interval timer is frozen. Clearing the bit sends SELFX, raises SCKE and restarts the timer from a full period. When the mode bit says that SCKE carries command information, the self-refresh request is locked out entirely.

Top module: `sdram_refresh_seq`

## Requirements
- R1: The first refresh request after reset, and each later one, is raised exactly (rc_cfg + 1) * 16 clocks after the previous timer start. rc_cfg takes effect when the timer reloads.
- R2: ref_req stays high until a cycle in which arb_grant is also high. ref_cmd pulses for one cycle in the next cycle, and ref_req drops in that same cycle.
- R3: busy goes high in the ref_cmd cycle and stays high for exactly N cycles, with N taken from rec_code at issue: 00 gives 3, 01 gives 6, 10 or 11 gives 9. One REF and one recovery window serve both memory blocks.
- R4: No REF and no SELF is issued while busy is high. busy is low whenever no recovery window and no self-refresh is in progress.
- R5: With cmd_on_cke at 0, a cycle in running state with selfref_req and arb_idle high, and no REF being issued, gives a one-cycle self_cmd in the next cycle. From that cycle on, scke is low and busy is high until exit.
- R6: In self-refresh, a cycle with selfref_req low (or cmd_on_cke high) gives a one-cycle selfx_cmd in the next cycle, with scke high and busy low.
- R7: While in self-refresh, the interval timer is suspended and ref_req stays low. A request pending at entry is dropped.
- R8: On exit, the timer reloads the full period, so ref_req rises exactly (rc_cfg + 1) * 16 cycles after the selfx_cmd cycle.
- R9: With cmd_on_cke at 1, selfref_req is ignored: self_cmd never pulses and scke stays high.
- R10: While rst is high, ref_req, ref_cmd, self_cmd, selfx_cmd and busy are low and scke is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_cfg | input | RC_W (9) | Refresh count; period is (rc_cfg+1)*16 clocks |
| rec_code | input | 2 | Recovery code: 00=3, 01=6, 1x=9 clocks |
| selfref_req | input | 1 | Request to enter and stay in self-refresh |
| cmd_on_cke | input | 1 | 1: SCKE carries command data, self-refresh locked out |
| arb_grant | input | 1 | Arbiter grants the command slot for REF |
| arb_idle | input | 1 | No access in progress, SELF may be sent |
| ref_req | output | 1 | Refresh pending toward the arbiter |
| ref_cmd | output | 1 | One-cycle REF command to both blocks |
| self_cmd | output | 1 | One-cycle SELF command |
| selfx_cmd | output | 1 | One-cycle SELFX command |
| scke | output | 1 | SDRAM clock enable level |
| busy | output | 1 | Holds off row activation |

## Verification
A corrupted interval count shows up at the ports as a ref_req edge in the wrong cycle. It appears no later than one period, and the per-cycle reference model catches it to the exact cycle. A wrong recovery counter or state register changes the length of busy, or lets a REF or SELF through early, within at most nine cycles of a REF. A wrong self-refresh state shows at once as scke at the wrong level or a missing or extra SELF/SELFX pulse. A timer that is not frozen or not reloaded shows as a ref_req during self-refresh, or as the first refresh after exit arriving early.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  localparam int REC_W = 4;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_RECOV = 2'd1,
    ST_SELF  = 2'd2
  } seq_state_t;

  // recovery length minus one, shared by both memory blocks
  function automatic logic [REC_W-1:0] rec_len_m1(input logic [1:0] code);
    case (code)
      2'b00:   rec_len_m1 = REC_W'(2);
      2'b01:   rec_len_m1 = REC_W'(5);
      default: rec_len_m1 = REC_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int RC_W      = 9,
  parameter int STEP_LOG2 = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RC_W-1:0] rc_cfg,
  input  logic            hold,
  input  logic            reload,
  output logic            tick
);
  localparam int CNT_W = RC_W + STEP_LOG2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period_m1;

  // (rc+1)*2^STEP_LOG2 - 1 == rc concatenated with all-ones
  assign period_m1 = {rc_cfg, {STEP_LOG2{1'b1}}};
  assign tick      = !hold && !reload && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt <= period_m1;
    end else if (!hold) begin
      if (cnt == '0) cnt <= period_m1;
      else           cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ref_recovery_counter.sv
module ref_recovery_counter
  import sdram_ref_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] code,
  output logic       done
);
  logic [REC_W-1:0] rcnt;

  assign done = (rcnt == '0);

  always_ff @(posedge clk) begin
    if (rst)              rcnt <= '0;
    else if (load)        rcnt <= rec_len_m1(code);
    else if (rcnt != '0)  rcnt <= rcnt - REC_W'(1);
  end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_ref_pkg::*;
#(
  parameter int RC_W      = 9,
  parameter int STEP_LOG2 = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RC_W-1:0] rc_cfg,
  input  logic [1:0]      rec_code,
  input  logic            selfref_req,
  input  logic            cmd_on_cke,
  input  logic            arb_grant,
  input  logic            arb_idle,
  output logic            ref_req,
  output logic            ref_cmd,
  output logic            self_cmd,
  output logic            selfx_cmd,
  output logic            scke,
  output logic            busy
);
  seq_state_t state, state_n;
  logic pending;
  logic issue, enter_self, leave_self;
  logic tick, rec_done;

  ref_interval_timer #(.RC_W(RC_W), .STEP_LOG2(STEP_LOG2)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .rc_cfg (rc_cfg),
    .hold   (state == ST_SELF),
    .reload (leave_self),
    .tick   (tick)
  );

  ref_recovery_counter u_recov (
    .clk  (clk),
    .rst  (rst),
    .load (issue),
    .code (rec_code),
    .done (rec_done)
  );

  assign ref_req = pending;

  always_comb begin
    issue      = (state == ST_RUN) && pending && arb_grant;
    enter_self = (state == ST_RUN) && !issue && selfref_req && !cmd_on_cke && arb_idle;
    leave_self = (state == ST_SELF) && (!selfref_req || cmd_on_cke);
    state_n    = state;
    case (state)
      ST_RUN: begin
        if (issue)           state_n = ST_RECOV;
        else if (enter_self) state_n = ST_SELF;
      end
      ST_RECOV: if (rec_done)   state_n = ST_RUN;
      ST_SELF:  if (leave_self) state_n = ST_RUN;
      default:                  state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      pending   <= 1'b0;
      ref_cmd   <= 1'b0;
      self_cmd  <= 1'b0;
      selfx_cmd <= 1'b0;
      scke      <= 1'b1;
      busy      <= 1'b0;
    end else begin
      state     <= state_n;
      pending   <= enter_self ? 1'b0 : (tick | (pending & ~issue));
      ref_cmd   <= issue;
      self_cmd  <= enter_self;
      selfx_cmd <= leave_self;
      scke      <= (state_n != ST_SELF);
      busy      <= (state_n != ST_RUN);
    end
  end
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk (
  input logic clk,
  input logic rst,
  input logic selfref_req,
  input logic cmd_on_cke,
  input logic arb_grant,
  input logic ref_req,
  input logic ref_cmd,
  input logic self_cmd,
  input logic selfx_cmd,
  input logic scke,
  input logic busy
);
  p_ref_after_grant_r2: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |-> $past(ref_req && arb_grant));

  p_busy_on_ref_r3: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |-> busy);

  p_no_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |=> !ref_cmd && !self_cmd);

  p_self_holds_busy_r5: assert property (@(posedge clk) disable iff (rst)
    !scke |-> busy);

  p_self_scke_low_r5: assert property (@(posedge clk) disable iff (rst)
    self_cmd |-> !scke);

  p_exit_raises_scke_r6: assert property (@(posedge clk) disable iff (rst)
    selfx_cmd |-> scke && $past(!scke));

  p_no_req_in_self_r7: assert property (@(posedge clk) disable iff (rst)
    !scke |-> !ref_req);

  p_coc_no_self_r9: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_on_cke) |-> !self_cmd);

  p_coc_scke_high_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_on_cke && $past(cmd_on_cke)) |-> scke);
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .selfref_req (selfref_req),
  .cmd_on_cke  (cmd_on_cke),
  .arb_grant   (arb_grant),
  .ref_req     (ref_req),
  .ref_cmd     (ref_cmd),
  .self_cmd    (self_cmd),
  .selfx_cmd   (selfx_cmd),
  .scke        (scke),
  .busy        (busy)
);

// File: tb/test_sdram_refresh_seq.sv
module test_sdram_refresh_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] rc_cfg = 9'd2;
  logic [1:0] rec_code = 2'b00;
  logic       selfref_req = 1'b0, cmd_on_cke = 1'b0;
  logic       arb_grant = 1'b0, arb_idle = 1'b0;
  logic       ref_req, ref_cmd, self_cmd, selfx_cmd, scke, busy;

  int checks = 0, errors = 0;
  bit started = 0, finished = 0;

  always #10 clk = ~clk;

  sdram_refresh_seq i_sdram_refresh_seq (
    .clk(clk), .rst(rst), .rc_cfg(rc_cfg), .rec_code(rec_code),
    .selfref_req(selfref_req), .cmd_on_cke(cmd_on_cke),
    .arb_grant(arb_grant), .arb_idle(arb_idle),
    .ref_req(ref_req), .ref_cmd(ref_cmd), .self_cmd(self_cmd),
    .selfx_cmd(selfx_cmd), .scke(scke), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int period(input int rc);
    return (rc + 1) * 16;
  endfunction

  function automatic int rec_len(input logic [1:0] c);
    return (c == 2'b00) ? 3 : (c == 2'b01) ? 6 : 9;
  endfunction

  // behavioural reference model
  int m_until, m_rec;
  bit m_pend, m_self;
  bit m_req, m_ref, m_sc, m_sx, m_scke, m_busy;
  bit mi, me, mx, mt;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_until = period(int'(rc_cfg)) - 1;
      m_pend = 0; m_self = 0; m_rec = 0;
      m_ref = 0; m_sc = 0; m_sx = 0; m_scke = 1; m_busy = 0;
    end else begin
      mi = m_pend && arb_grant && !m_self && (m_rec == 0);
      me = !mi && !m_self && (m_rec == 0) && selfref_req && !cmd_on_cke && arb_idle;
      mx = m_self && (!selfref_req || cmd_on_cke);
      mt = !m_self && (m_until == 0);
      if (mx)              m_until = period(int'(rc_cfg)) - 1;
      else if (!m_self)    m_until = (m_until == 0) ? period(int'(rc_cfg)) - 1 : m_until - 1;
      m_pend = me ? 0 : (mt || (m_pend && !mi));
      if (mi)              m_rec = rec_len(rec_code);
      else if (m_rec > 0)  m_rec = m_rec - 1;
      if (me) m_self = 1;
      if (mx) m_self = 0;
      m_ref = mi; m_sc = me; m_sx = mx;
      m_scke = !m_self;
      m_busy = m_self || (m_rec > 0);
    end
    m_req = m_pend;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(ref_req == m_req,     "R1 ref_req",   ref_req,   m_req);
      chk(ref_cmd == m_ref,     "R2 ref_cmd",   ref_cmd,   m_ref);
      chk(busy == m_busy,       "R3 busy",      busy,      m_busy);
      chk(self_cmd == m_sc,     "R5 self_cmd",  self_cmd,  m_sc);
      chk(selfx_cmd == m_sx,    "R6 selfx_cmd", selfx_cmd, m_sx);
      chk(scke == m_scke,       "R9 scke",      scke,      m_scke);
    end
  end

  task automatic count_to_req(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_req && n < 10000);
  endtask

  task automatic measure_rec(input logic [1:0] code);
    int nb;
    rec_code = code;
    while (!ref_cmd) @(negedge clk);
    nb = 0;
    while (busy) begin nb++; @(negedge clk); end
    chk(nb == rec_len(code), "R3 recovery length", nb, rec_len(code));
    chk(busy == 1'b0, "R4 busy low after window", busy, 0);
  endtask

  initial begin
    int n, cnt_bad;
    repeat (3) @(negedge clk);
    chk({ref_req, ref_cmd, self_cmd, selfx_cmd, busy, scke} == 6'b000001,
        "R10 reset outputs", {ref_req, ref_cmd, self_cmd, selfx_cmd, busy, scke}, 1);
    rst = 1'b0;
    count_to_req(n);
    chk(n == 48, "R1 first request", n, 48);

    repeat (20) @(negedge clk);
    chk(ref_req && !ref_cmd, "R2 request held without grant", {ref_req, ref_cmd}, 2);
    arb_grant = 1'b1;
    @(negedge clk);
    chk(ref_cmd && busy && !ref_req, "R2 REF after grant", {ref_cmd, busy, ref_req}, 6);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 3, "R3 recovery code 00", n, 3);

    while (!ref_req) @(negedge clk);
    count_to_req(n);
    chk(n == 48, "R1 steady interval", n, 48);

    measure_rec(2'b01);
    measure_rec(2'b10);
    measure_rec(2'b11);

    // self request raised while a refresh wins the slot
    rec_code = 2'b00;
    while (!ref_req) @(negedge clk);
    selfref_req = 1'b1; arb_idle = 1'b1;
    @(negedge clk);
    chk(ref_cmd && !self_cmd, "R4 refresh before self entry", {ref_cmd, self_cmd}, 2);
    cnt_bad = 0;
    while (busy) begin if (self_cmd) cnt_bad++; @(negedge clk); end
    chk(cnt_bad == 0, "R4 no SELF during recovery", cnt_bad, 0);
    @(negedge clk);
    chk(self_cmd && !scke && busy, "R5 SELF entry", {self_cmd, scke, busy}, 5);

    cnt_bad = 0;
    repeat (150) begin @(negedge clk); if (ref_req || scke) cnt_bad++; end
    chk(cnt_bad == 0, "R7 timer frozen in self-refresh", cnt_bad, 0);

    selfref_req = 1'b0;
    @(negedge clk);
    chk(selfx_cmd && scke && !busy, "R6 SELFX exit", {selfx_cmd, scke, busy}, 6);
    count_to_req(n);
    chk(n == 48, "R8 full period after exit", n, 48);

    cmd_on_cke = 1'b1; selfref_req = 1'b1;
    cnt_bad = 0;
    repeat (100) begin @(negedge clk); if (self_cmd || !scke) cnt_bad++; end
    chk(cnt_bad == 0, "R9 self request locked out", cnt_bad, 0);
    cmd_on_cke = 1'b0; selfref_req = 1'b0; arb_idle = 1'b0;

    rst = 1'b1; rc_cfg = 9'd0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    count_to_req(n);
    chk(n == 16, "R1 shortest period", n, 16);

    rst = 1'b1; rc_cfg = 9'd511;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    count_to_req(n);
    chk(n == 8192, "R1 longest period", n, 8192);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule